// File: doc/BRIEF.md
# External Memory Bus Arbiter with Pin-Group Drive Control

This block decides which of four agents owns an external memory bus: an external bus-release requester, a DRAM refresh requester, a DMA controller and the CPU. It holds a registered one-hot grant. The grant moves only at a transfer boundary. A boundary is either a `done` pulse from the current owner or the owner dropping its request. The CPU owns the bus whenever nobody else asks for it.

A configuration bit can lock the bus to the DMA controller while a DMA burst is in progress. While the lock holds, bus-release and refresh requests wait until the final beat completes. The block also produces two output-enable signals in place of tristate drivers. One covers the address/strobe pin group and the other covers the DRAM control pin group. Each enable follows the standby input, the bus-release grant and its own drive-policy bit.

The configuration is three bits, written all at once through `cfg_we`. The burst-lock bit is cleared only by the power-on reset. The two drive-policy bits are also cleared by the ordinary reset.

Top module: `membus_arbiter`

## Requirements
- R1: While either reset is low at a clock edge, the grant becomes CPU-only (`gnt` = 4'b0001) and both drive-policy bits become 0. With `standby` = 0, both enables are then 1.
- R2: `gnt` is always one-hot, with bit 3 = bus release, bit 2 = refresh, bit 1 = DMA and bit 0 = CPU. It changes only on a clock edge where `done` is 1 or the current owner's request is 0. The new value is visible right after that edge.
- R3: At a boundary with no lock active, the new owner is chosen by fixed priority: bus release, then refresh, then DMA, then CPU.
- R4: At a boundary with no request asserted, the CPU is granted.
- R5: The lock is active when the burst-lock bit is 1, DMA owns the bus and `dma_burst` is 1. While it is active, the grant stays with DMA even if `done` is 1 and release or refresh is requested. `dma_burst` is 1 on every beat except the final one, and it is 0 in the cycle of the final `done`.
- R6: With the burst-lock bit 0, a `done` from DMA while `dma_burst` is 1 is an ordinary boundary. A pending release or refresh takes the bus at that edge.
- R7: When the lock ends, requests that are still pending are served in the normal order of R3. A waiting refresh is granted when no release is pending.
- R8: `cfg_we` loads `cfg_din`, where bit 0 = address/strobe drive policy, bit 1 = DRAM-control drive policy and bit 2 = burst lock. `rst_n` low does not clear the burst-lock bit. `por_n` low clears it.
- R9: `oe_addr` is 0 while the bus-release grant is held. Otherwise it is 1 when `standby` = 0, and equals the address/strobe policy bit when `standby` = 1.
- R10: `oe_ctrl` is 1 whenever the DRAM-control policy bit is 1. With that bit 0, `oe_ctrl` is 0 during standby or the bus-release grant, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Ordinary reset, active low, synchronous |
| cfg_we | input | 1 | Loads the configuration bits |
| cfg_din | input | 3 | Configuration value: {burst lock, control policy, address policy} |
| req_rel | input | 1 | External bus-release request |
| req_ref | input | 1 | DRAM refresh request |
| req_dma | input | 1 | DMA controller request |
| req_cpu | input | 1 | CPU request |
| done | input | 1 | End of the current owner's transfer |
| dma_burst | input | 1 | A DMA burst is in progress and this is not its final beat |
| standby | input | 1 | Standby mode |
| gnt | output | 4 | One-hot grant {release, refresh, DMA, CPU} |
| oe_addr | output | 1 | Drive enable for the address/strobe pin group |
| oe_ctrl | output | 1 | Drive enable for the DRAM control pin group |

## Verification
A corrupted grant register shows on `gnt` in the cycle after the edge that loads it. It shows either as a code that is not one-hot or as an owner that the priority order would not have picked. A lock bit set wrongly, or lost across the ordinary reset, shows at the next DMA beat boundary that has release or refresh pending: the grant stays with DMA or leaves it when it should not. A wrong drive-policy bit shows at once on the enables, as soon as `standby` or the release grant selects that bit.

// File: rtl/membus_arbiter.sv
module membus_arbiter #(
  parameter int NREQ = 4
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [2:0]      cfg_din,
  input  logic            req_rel,
  input  logic            req_ref,
  input  logic            req_dma,
  input  logic            req_cpu,
  input  logic            done,
  input  logic            dma_burst,
  input  logic            standby,
  output logic [NREQ-1:0] gnt,
  output logic            oe_addr,
  output logic            oe_ctrl
);
  localparam int REL = NREQ - 1;
  localparam int REF = NREQ - 2;
  localparam int DMA = 1;
  localparam int CPU = 0;

  logic [NREQ-1:0] gnt_q, pick, reqv;
  logic            lock_q, hiz_addr_q, hiz_ctrl_q;
  logic            any_rst, owner_req, boundary, hold;

  assign any_rst   = !por_n || !rst_n;
  assign reqv      = {req_rel, req_ref, req_dma, req_cpu};
  assign owner_req = |(gnt_q & reqv);
  assign boundary  = done || !owner_req;
  assign hold      = lock_q && gnt_q[DMA] && dma_burst;

  always_comb begin
    pick = '0;
    if (req_rel)      pick[REL] = 1'b1;
    else if (req_ref) pick[REF] = 1'b1;
    else if (req_dma) pick[DMA] = 1'b1;
    else              pick[CPU] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!por_n)      lock_q <= 1'b0;
    else if (cfg_we) lock_q <= cfg_din[2];
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      hiz_addr_q <= 1'b0;
      hiz_ctrl_q <= 1'b0;
    end else if (cfg_we) begin
      hiz_addr_q <= cfg_din[0];
      hiz_ctrl_q <= cfg_din[1];
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst)                gnt_q <= NREQ'(1);
    else if (boundary && !hold) gnt_q <= pick;
  end

  assign gnt     = gnt_q;
  assign oe_addr = !gnt_q[REL] && (!standby || hiz_addr_q);
  assign oe_ctrl = hiz_ctrl_q || !(standby || gnt_q[REL]);

  a_r2_onehot: assert property (@(posedge clk) disable iff (any_rst)
    $countones(gnt) == 1);

  a_r2_stable: assert property (@(posedge clk) disable iff (any_rst)
    (!done && (|(gnt & {req_rel, req_ref, req_dma, req_cpu}))) |=> $stable(gnt));

  a_r3_release_first: assert property (@(posedge clk) disable iff (any_rst)
    (done && req_rel && !(lock_q && gnt[DMA] && dma_burst)) |=> gnt[REL]);

  a_r5_lock_holds: assert property (@(posedge clk) disable iff (any_rst)
    (lock_q && gnt[DMA] && dma_burst) |=> gnt[DMA]);

  a_r9_release_floats: assert property (@(posedge clk) disable iff (any_rst)
    gnt[REL] |-> !oe_addr);

  a_r10_ctrl_driven: assert property (@(posedge clk) disable iff (any_rst)
    (!standby && !gnt[REL]) |-> oe_ctrl);
endmodule

// File: tb/membus_arbiter_bench.sv
module membus_arbiter_bench;
  logic clk = 0;
  logic por_n, rst_n, cfg_we, req_rel, req_ref, req_dma, req_cpu, done, dma_burst, standby;
  logic [2:0] cfg_din;
  logic [3:0] gnt;
  logic oe_addr, oe_ctrl;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  membus_arbiter u_membus_arbiter (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_din(cfg_din),
    .req_rel(req_rel), .req_ref(req_ref), .req_dma(req_dma), .req_cpu(req_cpu),
    .done(done), .dma_burst(dma_burst), .standby(standby),
    .gnt(gnt), .oe_addr(oe_addr), .oe_ctrl(oe_ctrl));

  // {requests rel,ref,dma,cpu ; expected grant}
  localparam logic [7:0] VEC [10] = '{
    8'b0000_0001, 8'b0001_0001, 8'b0010_0010, 8'b0011_0010, 8'b0100_0100,
    8'b0110_0100, 8'b0101_0100, 8'b1000_1000, 8'b1010_1000, 8'b1111_1000};

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #2;
  endtask

  task automatic setreq(logic [3:0] r);
    {req_rel, req_ref, req_dma, req_cpu} = r;
  endtask

  task automatic wcfg(logic [2:0] v);
    cfg_din = v; cfg_we = 1; tick; cfg_we = 0;
  endtask

  task automatic get_dma;
    setreq(4'b0010); done = 1; tick; done = 0;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    por_n = 0; rst_n = 0; cfg_we = 0; cfg_din = 0; setreq(4'b0000);
    done = 0; dma_burst = 0; standby = 0;
    tick; tick; por_n = 1; rst_n = 1;
    chk("R1 grant", gnt, 4'b0001);
    chk("R1 enables", {2'b0, oe_addr, oe_ctrl}, 4'b0011);

    // R3 R4 priority table
    foreach (VEC[i]) begin
      setreq(VEC[i][7:4]); done = 1; tick;
      chk($sformatf("R3 R4 vec%0d", i), gnt, VEC[i][3:0]);
    end
    done = 0;

    // R2 hold without boundary, then move at done
    get_dma; setreq(4'b1010); tick;
    chk("R2 hold", gnt, 4'b0010);
    done = 1; tick; done = 0;
    chk("R2 move at done", gnt, 4'b1000);
    // R2 idle owner is a boundary
    setreq(4'b0000); tick;
    chk("R2 idle owner", gnt, 4'b0001);
    setreq(4'b0010); tick;
    chk("R2 idle cpu to dma", gnt, 4'b0010);

    // R6 no lock: refresh preempts a beat
    dma_burst = 1; setreq(4'b0110); done = 1; tick; done = 0;
    chk("R6 preempt", gnt, 4'b0100);
    dma_burst = 0;

    // R5 lock
    wcfg(3'b100);
    get_dma; dma_burst = 1; setreq(4'b1110); done = 1; tick;
    chk("R5 lock vs release", gnt, 4'b0010);
    tick;
    chk("R5 lock second beat", gnt, 4'b0010);
    // R7 end of burst, refresh waiting
    setreq(4'b0110); dma_burst = 0; tick; done = 0;
    chk("R7 refresh after burst", gnt, 4'b0100);

    // R8 lock survives rst_n
    rst_n = 0; tick; rst_n = 1;
    get_dma; dma_burst = 1; setreq(4'b1010); done = 1; tick; done = 0;
    chk("R8 lock kept over rst_n", gnt, 4'b0010);
    dma_burst = 0;
    por_n = 0; tick; por_n = 1;
    get_dma; dma_burst = 1; setreq(4'b1010); done = 1; tick; done = 0;
    chk("R8 lock cleared by por_n", gnt, 4'b1000);
    dma_burst = 0; setreq(4'b0000); done = 1; tick; done = 0;

    // R9 R10 enables, owner CPU
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 4; c++) begin
        wcfg(3'(c)); standby = s[0];
        #1;
        chk($sformatf("R9 s%0d c%0d", s, c), {3'b0, oe_addr}, {3'b0, !standby || c[0]});
        chk($sformatf("R10 s%0d c%0d", s, c), {3'b0, oe_ctrl}, {3'b0, c[1] || !standby});
      end
    standby = 0;
    // release grant
    for (int c = 0; c < 4; c++) begin
      wcfg(3'(c)); setreq(4'b1000); done = 1; tick; done = 0;
      chk($sformatf("R9 release c%0d", c), {3'b0, oe_addr}, 4'b0);
      chk($sformatf("R10 release c%0d", c), {3'b0, oe_ctrl}, {3'b0, c[1]});
    end
    // R8 rst_n clears policy bits
    setreq(4'b0000); done = 1; tick; done = 0;
    wcfg(3'b011); standby = 1; #1;
    chk("R8 policy set", {2'b0, oe_addr, oe_ctrl}, 4'b0011);
    rst_n = 0; tick; rst_n = 1; #1;
    chk("R1 R8 policy cleared", {2'b0, oe_addr, oe_ctrl}, 4'b0000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule